// File: doc/BRIEF.md
# Serial Control Port Secondary

This block is the responding end of a byte-oriented, full-duplex, synchronous serial control port. A host drives a serial clock, an active-low access enable and a serial data line. The block answers on a data line that it can only pull low or release, so a released line reads as 1. Each access carries up to three bytes. The first is a command byte, the second is a register address, and the third is either the write data or the read data returned by the block. Bits travel most significant first. The block captures input bits on the falling edge of the serial clock and changes its output bit on the rising edge.

The serial clock, the enable and the input data pass through equal-depth synchronisers into the system clock domain. All framing runs from edges found on the synchronised clock, so the system clock must run at least four times faster than the serial clock. A small register file sits behind the port. It holds a write-one-to-clear interrupt status register, an interrupt mask register and a parameterised number of general configuration registers. The general registers are brought out as a flat vector. A separate open-drain interrupt line is pulled low whenever a pending status bit is also enabled in the mask.

Top module: `sctl_secondary`

## Requirements
- R1: After reset, and whenever the access enable has been high for four system clocks, `sdo_pull_low` is 0 (the data line is released).
- R2: A write access writes the third byte to the addressed register once its eighth bit is captured. The command byte has bit 7 = 0 and the address is in the second byte. General register k sits at address 0x02+k and appears on `cfg_regs[8k+7:8k]`.
- R3: A read access is a command byte with bit 7 = 1. The block returns the addressed register MSB first, one bit per serial clock, during the third byte. The line stays released during the first two bytes.
- R4: Bits 6..0 of the command byte are ignored. Command 0x7F acts as a write and 0xFF acts as a read.
- R5: Raising the access enable before the 24th bit is captured discards the access. No register changes, and the next access is decoded normally.
- R6: The status register at address 0x00 is write-one-to-clear. Bits written as 1 clear and bits written as 0 are kept. The mask register at 0x01 is read/write.
- R7: A pulse on `irq_src[i]` sets status bit i. If that pulse falls in the same system cycle as a status write that clears bit i, the set wins.
- R8: `irq_pull_low` is 1 exactly when (status AND mask) is non-zero.
- R9: Addresses above 0x01+NGEN read as 0x00, and writes to them change no register.
- R10: After reset, the status, mask and all general registers are 0, and `irq_pull_low` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock from the host |
| ser_en_n | input | 1 | Access enable, active low |
| ser_din | input | 1 | Serial data from the host |
| irq_src | input | 8 | Interrupt event pulses, one per status bit |
| sdo_pull_low | output | 1 | 1 = pull serial output low, 0 = release |
| irq_pull_low | output | 1 | 1 = pull interrupt request low |
| cfg_regs | output | 8*NGEN | General registers, register k at bits 8k+7:8k |

## Verification
Two updates can land on the status register in the same system cycle. One is an event pulse on `irq_src` that sets a bit. The other is a serial write to address 0x00 whose eighth data bit clears that same bit. The bench counts register stages from the falling serial clock edge of the last data bit: two synchroniser flops, then the edge detector. It raises the matching `irq_src` bit exactly in the cycle the write strobe is sampled. It then reads the status back over the port and expects the bit still set, and it confirms that a later clear without an event removes it.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Position of the access inside its three-byte frame
    typedef enum logic [1:0] {
        PH_CMD,
        PH_ADDR,
        PH_DATA,
        PH_DONE
    } phase_e;

    // Events seen on the synchronised serial lines
    typedef struct packed {
        logic rise;
        logic fall;
        logic en;
        logic din;
    } ser_ev_t;

    // Register write request leaving the framer
    typedef struct packed {
        logic  stb;
        byte_t addr;
        byte_t data;
    } wr_req_t;

    localparam byte_t ADDR_STATUS = 8'h00;
    localparam byte_t ADDR_MASK   = 8'h01;
    localparam byte_t ADDR_GEN0   = 8'h02;

    // Write-one-to-clear with event set taking priority
    function automatic byte_t w1c_update(byte_t cur, byte_t clr, byte_t set);
        return (cur & ~clr) | set;
    endfunction

    function automatic logic cmd_is_read(byte_t cmd);
        return cmd[BYTE_W-1];
    endfunction

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int          W       = 1,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{RST_VAL}};
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sctl_edge.sv
module sctl_edge
    import sctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    ser_clk,
    input  logic    ser_en_n,
    input  logic    ser_din,
    output ser_ev_t ev
);
    logic [2:0] raw;
    logic [2:0] synced;
    logic       clk_prev;

    assign raw = {ser_clk, ser_en_n, ser_din};

    // Clock and enable idle high, data idles low; equal depth keeps them aligned
    sctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    always_ff @(posedge clk) begin
        if (rst) clk_prev <= 1'b1;
        else     clk_prev <= synced[2];
    end

    always_comb begin
        ev.rise = synced[2] & ~clk_prev;
        ev.fall = ~synced[2] & clk_prev;
        ev.en   = ~synced[1];
        ev.din  = synced[0];
    end
endmodule

// File: rtl/sctl_frame.sv
module sctl_frame
    import sctl_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ser_ev_t ev,
    input  byte_t   rd_data,
    output byte_t   rd_addr,
    output wr_req_t wr,
    output logic    sdo_pull_low
);
    phase_e     phase;
    logic [2:0] bit_cnt;
    byte_t      sh_in;
    byte_t      addr_q;
    byte_t      rd_sh;
    logic       is_rd;
    logic       out_bit;
    logic       drive;
    byte_t      byte_next;
    logic       last_bit;

    assign byte_next = {sh_in[BYTE_W-2:0], ev.din};
    assign last_bit  = (bit_cnt == 3'd7);

    always_ff @(posedge clk) begin
        if (rst || !ev.en) begin
            phase   <= PH_CMD;
            bit_cnt <= '0;
            sh_in   <= '0;
            addr_q  <= '0;
            rd_sh   <= '0;
            is_rd   <= 1'b0;
            out_bit <= 1'b1;
            drive   <= 1'b0;
        end else begin
            if (ev.fall && phase != PH_DONE) begin
                sh_in   <= byte_next;
                bit_cnt <= bit_cnt + 3'd1;
                if (last_bit) begin
                    case (phase)
                        PH_CMD: begin
                            is_rd <= cmd_is_read(byte_next);
                            phase <= PH_ADDR;
                        end
                        PH_ADDR: begin
                            addr_q <= byte_next;
                            phase  <= PH_DATA;
                            if (is_rd) begin
                                rd_sh <= rd_data;
                                drive <= 1'b1;
                            end
                        end
                        PH_DATA: begin
                            phase   <= PH_DONE;
                            drive   <= 1'b0;
                            out_bit <= 1'b1;
                        end
                        default: phase <= PH_DONE;
                    endcase
                end
            end
            // Output bit launched on the serial rising edge
            if (ev.rise && phase == PH_DATA && is_rd) begin
                out_bit <= rd_sh[BYTE_W-1];
                rd_sh   <= {rd_sh[BYTE_W-2:0], 1'b0};
            end
        end
    end

    assign rd_addr = byte_next;

    always_comb begin
        wr.stb  = ev.en && ev.fall && last_bit && (phase == PH_DATA) && !is_rd;
        wr.addr = addr_q;
        wr.data = byte_next;
    end

    assign sdo_pull_low = drive & ~out_bit;
endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
    import sctl_pkg::*;
#(
    parameter int NGEN = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  wr_req_t                wr,
    input  byte_t                  rd_addr,
    input  byte_t                  irq_src,
    output byte_t                  rd_data,
    output byte_t                  status,
    output logic [NGEN*BYTE_W-1:0] gen_flat,
    output logic                   irq_pull_low
);
    byte_t status_q;
    byte_t mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '0;
            mask_q   <= '0;
        end else begin
            if (wr.stb && wr.addr == ADDR_STATUS)
                status_q <= w1c_update(status_q, wr.data, irq_src);
            else
                status_q <= status_q | irq_src;
            if (wr.stb && wr.addr == ADDR_MASK)
                mask_q <= wr.data;
        end
    end

    for (genvar g = 0; g < NGEN; g++) begin : g_gen
        localparam byte_t MY_ADDR = byte_t'(int'(ADDR_GEN0) + g);
        byte_t q;
        always_ff @(posedge clk) begin
            if (rst)                               q <= '0;
            else if (wr.stb && wr.addr == MY_ADDR) q <= wr.data;
        end
        assign gen_flat[g*BYTE_W +: BYTE_W] = q;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_STATUS)    rd_data = status_q;
        else if (rd_addr == ADDR_MASK) rd_data = mask_q;
        for (int g = 0; g < NGEN; g++) begin
            if (rd_addr == byte_t'(int'(ADDR_GEN0) + g))
                rd_data = gen_flat[g*BYTE_W +: BYTE_W];
        end
    end

    assign status       = status_q;
    assign irq_pull_low = |(status_q & mask_q);
endmodule

// File: rtl/sctl_secondary.sv
module sctl_secondary
    import sctl_pkg::*;
#(
    parameter int NGEN        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   ser_clk,
    input  logic                   ser_en_n,
    input  logic                   ser_din,
    input  logic [BYTE_W-1:0]      irq_src,
    output logic                   sdo_pull_low,
    output logic                   irq_pull_low,
    output logic [NGEN*BYTE_W-1:0] cfg_regs
);
    ser_ev_t ev;
    wr_req_t wr;
    byte_t   rd_addr;
    byte_t   rd_data;
    byte_t   status_w;
    logic    wr_stb_w;
    logic    ser_rise_w;

    sctl_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .ser_clk  (ser_clk),
        .ser_en_n (ser_en_n),
        .ser_din  (ser_din),
        .ev       (ev)
    );

    sctl_frame u_frame (
        .clk          (clk),
        .rst          (rst),
        .ev           (ev),
        .rd_data      (rd_data),
        .rd_addr      (rd_addr),
        .wr           (wr),
        .sdo_pull_low (sdo_pull_low)
    );

    sctl_regs #(.NGEN(NGEN)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .wr           (wr),
        .rd_addr      (rd_addr),
        .irq_src      (irq_src),
        .rd_data      (rd_data),
        .status       (status_w),
        .gen_flat     (cfg_regs),
        .irq_pull_low (irq_pull_low)
    );

    assign wr_stb_w   = wr.stb;
    assign ser_rise_w = ev.rise;
endmodule

// File: rtl/sctl_secondary_chk.sv
module sctl_secondary_chk (
    input logic       clk,
    input logic       rst,
    input logic       ser_en_n,
    input logic [7:0] irq_src,
    input logic       sdo_pull_low,
    input logic       irq_pull_low,
    input logic       wr_stb,
    input logic       ser_rise,
    input logic [7:0] status
);
    // R1: four idle cycles cover two synchroniser flops and the framer reset
    a_r1_idle_release: assert property (@(posedge clk) disable iff (rst)
        (ser_en_n && $past(ser_en_n) && $past(ser_en_n, 2) && $past(ser_en_n, 3))
        |-> !sdo_pull_low);

    // R2: one captured edge gives exactly one write strobe
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R3: the output only starts pulling low after a serial rising edge
    a_r3_launch_on_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_pull_low) |-> $past(ser_rise));

    // R7: an event always leaves its status bit set, even against a clear
    a_r7_event_sets: assert property (@(posedge clk) disable iff (rst)
        (irq_src != 8'h00) |=> ((status & $past(irq_src)) == $past(irq_src)));

    // R8: request appears only after an event or a register write
    a_r8_irq_rise_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pull_low) |-> (($past(irq_src) != 8'h00) || $past(wr_stb)));

    // R6: request can only be withdrawn by a register write
    a_r6_irq_fall_cause: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_pull_low) |-> $past(wr_stb));
endmodule

bind sctl_secondary sctl_secondary_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ser_en_n     (ser_en_n),
    .irq_src      (irq_src),
    .sdo_pull_low (sdo_pull_low),
    .irq_pull_low (irq_pull_low),
    .wr_stb       (wr_stb_w),
    .ser_rise     (ser_rise_w),
    .status       (status_w)
);

// File: tb/sim_sctl_secondary.sv
module sim_sctl_secondary;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int NGEN       = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b1;
    logic ser_en_n = 1'b1;
    logic ser_din = 1'b0;
    logic [7:0] irq_src = 8'h00;
    logic sdo_pull_low;
    logic irq_pull_low;
    logic [NGEN*8-1:0] cfg_regs;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  busy   = 1'b1;
    bit  ended  = 1'b0;

    // Behavioural model of the register file
    logic [7:0] m_status = 8'h00;
    logic [7:0] m_mask   = 8'h00;
    logic [7:0] m_gen [NGEN];

    always #(CLK_PERIOD/2) clk = ~clk;

    sctl_secondary #(.NGEN(NGEN)) u0 (
        .clk          (clk),
        .rst          (rst),
        .ser_clk      (ser_clk),
        .ser_en_n     (ser_en_n),
        .ser_din      (ser_din),
        .irq_src      (irq_src),
        .sdo_pull_low (sdo_pull_low),
        .irq_pull_low (irq_pull_low),
        .cfg_regs     (cfg_regs)
    );

    function automatic logic [NGEN*8-1:0] m_cfg();
        logic [NGEN*8-1:0] r = '0;
        for (int g = 0; g < NGEN; g++) r[g*8 +: 8] = m_gen[g];
        return r;
    endfunction

    function automatic void m_write(input logic [7:0] a, input logic [7:0] d, input logic [7:0] ev);
        if (a == 8'h00)      m_status = (m_status & ~d) | ev;
        else if (a == 8'h01) m_mask = d;
        else if (a >= 8'h02 && a < 8'(2 + NGEN)) m_gen[a - 8'h02] = d;
    endfunction

    function automatic logic [7:0] m_read(input logic [7:0] a);
        if (a == 8'h00) return m_status;
        if (a == 8'h01) return m_mask;
        if (a >= 8'h02 && a < 8'(2 + NGEN)) return m_gen[a - 8'h02];
        return 8'h00;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One access; nfalls < 24 aborts, pulse_bit >= 0 collides an event with the last bit
    task automatic xfer(input logic [7:0] cmd, input logic [7:0] addr, input logic [7:0] wd,
                        input int nfalls, input int pulse_bit,
                        output logic [7:0] rd, output int early_low);
        logic [23:0] frm;
        frm = {cmd, addr, wd};
        busy = 1'b1;
        rd = 8'h00;
        early_low = 0;
        @(negedge clk);
        ser_en_n = 1'b0;
        wait_cyc(HALF);
        for (int i = 0; i < nfalls; i++) begin
            ser_clk = 1'b1;
            ser_din = frm[23-i];
            wait_cyc(HALF);
            if (i >= 16) rd = {rd[6:0], ~sdo_pull_low};
            else if (sdo_pull_low) early_low++;
            ser_clk = 1'b0;
            if (i == 23 && pulse_bit >= 0) begin
                wait_cyc(2);
                irq_src = 8'(1 << pulse_bit);
                wait_cyc(1);
                irq_src = 8'h00;
                wait_cyc(HALF - 3);
            end else begin
                wait_cyc(HALF);
            end
        end
        ser_en_n = 1'b1;
        wait_cyc(HALF);
        ser_clk = 1'b1;
        wait_cyc(8);
        busy = 1'b0;
    endtask

    task automatic do_write(input logic [7:0] cmd, input logic [7:0] a, input logic [7:0] d);
        logic [7:0] rd;
        int el;
        xfer(cmd, a, d, 24, -1, rd, el);
        m_write(a, d, 8'h00);
    endtask

    task automatic do_read(input string req, input logic [7:0] cmd, input logic [7:0] a);
        logic [7:0] rd;
        int el;
        xfer(cmd, a, 8'h00, 24, -1, rd, el);
        check({req, " read data"}, 32'(rd), 32'(m_read(a)));
        check({req, " line released in first two bytes"}, 32'(el), 32'd0);
    endtask

    task automatic pulse(input logic [7:0] v);
        busy = 1'b1;
        @(negedge clk);
        irq_src = v;
        @(negedge clk);
        irq_src = 8'h00;
        m_status = m_status | v;
        wait_cyc(3);
        busy = 1'b0;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    // Per-clock comparison against the model while no access is in flight
    always @(negedge clk) begin
        if (!busy && !rst) begin
            check("R8 irq line vs model", 32'(irq_pull_low), 32'(|(m_status & m_mask)));
            check("R1 data line idle", 32'(sdo_pull_low), 32'd0);
            check("R2 cfg_regs vs model", 32'(cfg_regs), 32'(m_cfg()));
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        int el;
        for (int g = 0; g < NGEN; g++) m_gen[g] = 8'h00;
        wait_cyc(5);
        rst = 1'b0;
        wait_cyc(2);
        // R10 reset state
        check("R10 cfg after reset", 32'(cfg_regs), 32'd0);
        check("R10 irq after reset", 32'(irq_pull_low), 32'd0);
        check("R1 line after reset", 32'(sdo_pull_low), 32'd0);
        busy = 1'b0;
        do_read("R10 status", 8'h80, 8'h00);
        do_read("R10 mask", 8'h80, 8'h01);

        // R2 plain write, R4 command low bits ignored
        do_write(8'h00, 8'h02, 8'hA5);
        check("R2 gen0 written", 32'(cfg_regs[7:0]), 32'h0000_00A5);
        do_write(8'h7F, 8'h05, 8'h3C);
        check("R4 write with cmd 0x7F", 32'(cfg_regs[31:24]), 32'h0000_003C);
        do_write(8'h00, 8'h03, 8'h5A);

        // R3 reads, R4 read with cmd 0xFF
        do_read("R3 gen0", 8'h80, 8'h02);
        do_read("R4 read with cmd 0xFF", 8'hFF, 8'h05);
        do_read("R3 gen1", 8'h80, 8'h03);

        // R9 unmapped addresses
        do_write(8'h00, 8'h06, 8'hFF);
        do_write(8'h00, 8'h40, 8'h77);
        check("R9 unmapped write no effect", 32'(cfg_regs), 32'(m_cfg()));
        do_read("R9 read 0x06", 8'h80, 8'h06);
        do_read("R9 read 0xC3", 8'h80, 8'hC3);

        // R5 aborts at bit 20 and one bit short
        xfer(8'h00, 8'h04, 8'h99, 20, -1, rd, el);
        check("R5 abort at bit 20", 32'(cfg_regs[23:16]), 32'd0);
        xfer(8'h00, 8'h04, 8'h99, 23, -1, rd, el);
        check("R5 abort one bit short", 32'(cfg_regs[23:16]), 32'd0);
        do_write(8'h00, 8'h04, 8'h11);
        check("R5 access after abort", 32'(cfg_regs[23:16]), 32'h0000_0011);

        // R7 event sets status, R8 masked off
        pulse(8'h05);
        check("R8 masked event no request", 32'(irq_pull_low), 32'd0);
        do_read("R7 status after event", 8'h80, 8'h00);
        do_write(8'h00, 8'h01, 8'h04);
        check("R8 request with mask", 32'(irq_pull_low), 32'd1);
        // R6 write-one-to-clear
        do_write(8'h00, 8'h00, 8'h04);
        check("R6 request withdrawn after clear", 32'(irq_pull_low), 32'd0);
        do_read("R6 status keeps zero-written bit", 8'h80, 8'h00);
        do_write(8'h00, 8'h01, 8'h01);
        check("R8 request from bit0", 32'(irq_pull_low), 32'd1);
        do_read("R6 mask readback", 8'h80, 8'h01);

        // R7 collision: clear of bit0 meets event on bit0
        xfer(8'h00, 8'h00, 8'h01, 24, 0, rd, el);
        m_write(8'h00, 8'h01, 8'h01);
        do_read("R7 set wins over clear", 8'h80, 8'h00);
        check("R7 request held after collision", 32'(irq_pull_low), 32'd1);
        do_write(8'h00, 8'h00, 8'h01);
        check("R6 clear without event", 32'(irq_pull_low), 32'd0);
        do_read("R6 status cleared", 8'h80, 8'h00);

        wait_cyc(10);
        finish_run();
    end
endmodule